// File: doc/BRIEF.md
# LCD panel power sequencer

This block brings an LCD panel's supply, its serial link and its backlight up and down in a fixed order, so the panel never sees link data without power or a lit backlight without a valid picture. It is driven by a 1 ms enable tick from an external divider. Five programmable interval timers set the gaps between the steps. Each timer has its own step size and takes its count from a configuration input.

Power-up needs all of these to be true: the software link enable, PLL lock, and the stable flags for horizontal sync, vertical sync and the pixel clock. The order is: panel supply on, wait the first interval, mark link data valid, wait the second interval, then light the backlight. The backlight lights only if its configuration bit allows it. If any condition fails, power-down begins. Power-down drops the backlight, waits the third interval, marks data invalid, waits the fourth interval and removes the supply. A lockout interval then runs before another power-up is accepted. A power-down in progress always runs to its end. A configuration bit chooses whether the link pads float or are driven low while the link is invalid.

Top module: `lcd_pwr_seq`

## Requirements
- R1: During and after reset, with no power-up started, panel_vdd_en, link_valid and bkl_en are 0.
- R2: From the idle state, panel_vdd_en rises on the first clock edge at which link_en, pll_locked, hsync_ok, vsync_ok and pclk_ok are all 1.
- R3: After the supply rises, link_valid rises once t1_cfg*50 ticks have been counted, and bkl_en follows once t2_cfg*1 ticks have been counted. Each interval is counted from the edge that entered the step and ends one clock after its count reaches zero.
- R4: bkl_en is 1 only while fully powered up and bkl_allow is 1. When bkl_allow is 0, bkl_en stays 0 for the whole sequence.
- R5: While powering up or fully up, bkl_en drops on the first edge where any stability input or link_en is 0. link_valid then drops after t3_cfg*2 ticks, and panel_vdd_en drops t4_cfg*2 ticks after that.
- R6: Once power-down has begun, it completes even if every start condition returns partway through.
- R7: After panel_vdd_en falls, no power-up is accepted until t5_cfg*1 ticks have been counted, even with all start conditions held true.
- R8: link_oe is 1 when link_valid or gnd_idle is 1. link_zero is 1 exactly when gnd_idle is 1 and link_valid is 0.
- R9: A timer programmed to 0 adds no delay. The step advances on the next clock edge, so with all counts at 0 the supply, data valid and backlight rise on three successive edges.
- R10: An abort during the first interval skips the backlight and data steps. link_valid never rises, and the supply drops after the t4_cfg*2 tick interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle 1 ms time-base enable |
| link_en | input | 1 | Software link enable |
| pll_locked | input | 1 | PLL lock indication |
| hsync_ok | input | 1 | Horizontal sync stable |
| vsync_ok | input | 1 | Vertical sync stable |
| pclk_ok | input | 1 | Pixel clock stable |
| bkl_allow | input | 1 | Configuration: permit backlight |
| gnd_idle | input | 1 | Configuration: 1 drives idle link low, 0 floats it |
| t1_cfg | input | 6 | Supply-to-data interval, 50 ms units |
| t2_cfg | input | 10 | Data-to-backlight interval, 1 ms units |
| t3_cfg | input | 8 | Backlight-off-to-data-off interval, 2 ms units |
| t4_cfg | input | 8 | Data-off-to-supply-off interval, 2 ms units |
| t5_cfg | input | 10 | Restart lockout, 1 ms units |
| panel_vdd_en | output | 1 | Panel supply enable |
| link_valid | output | 1 | Link data valid qualifier |
| bkl_en | output | 1 | Backlight enable |
| link_oe | output | 1 | Link pad drivers enabled |
| link_zero | output | 1 | Force link pads to ground |

## Verification
The bench targets a few corner cases, each with a known bad behaviour.
- Return of conditions during power-down: a sequencer that re-evaluates its start conditions would climb back up without finishing.
- Conditions held true through the lockout: a design without the lockout would restore the supply as soon as it dropped.
- Failure during the first interval: a design that always takes the full down path would flash link_valid on.
- All-zero timer counts, and power-up with the backlight not allowed: errors here show up as extra or missing cycles, or as a lit backlight.
- Both idle pad modes are run, to catch swapped float and ground outputs.

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq #(
  parameter int T1_W = 6,
  parameter int T25_W = 10,
  parameter int T34_W = 8,
  parameter int T1_STEP = 50,
  parameter int T25_STEP = 1,
  parameter int T34_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             link_en,
  input  logic             pll_locked,
  input  logic             hsync_ok,
  input  logic             vsync_ok,
  input  logic             pclk_ok,
  input  logic             bkl_allow,
  input  logic             gnd_idle,
  input  logic [T1_W-1:0]  t1_cfg,
  input  logic [T25_W-1:0] t2_cfg,
  input  logic [T34_W-1:0] t3_cfg,
  input  logic [T34_W-1:0] t4_cfg,
  input  logic [T25_W-1:0] t5_cfg,
  output logic             panel_vdd_en,
  output logic             link_valid,
  output logic             bkl_en,
  output logic             link_oe,
  output logic             link_zero
);
  localparam int MAX1 = ((1 << T1_W) - 1) * T1_STEP;
  localparam int MAX25 = ((1 << T25_W) - 1) * T25_STEP;
  localparam int MAX34 = ((1 << T34_W) - 1) * T34_STEP;
  localparam int MAXA = (MAX1 > MAX25) ? MAX1 : MAX25;
  localparam int MAXMS = (MAXA > MAX34) ? MAXA : MAX34;
  localparam int CNT_W = $clog2(MAXMS + 1);

  typedef enum logic [2:0] {
    S_OFF, S_UP1, S_UP2, S_ON, S_DN3, S_DN4, S_LOCK
  } st_t;

  st_t st, nxt;
  logic [CNT_W-1:0] cnt, load;
  logic go, done;

  assign go   = link_en & pll_locked & hsync_ok & vsync_ok & pclk_ok;
  assign done = (cnt == '0);

  always_comb begin
    nxt = st;
    case (st)
      S_OFF:  if (go) nxt = S_UP1;
      S_UP1:  if (!go) nxt = S_DN4; else if (done) nxt = S_UP2;
      S_UP2:  if (!go) nxt = S_DN3; else if (done) nxt = S_ON;
      S_ON:   if (!go) nxt = S_DN3;
      S_DN3:  if (done) nxt = S_DN4;
      S_DN4:  if (done) nxt = S_LOCK;
      S_LOCK: if (done) nxt = S_OFF;
      default: nxt = S_OFF;
    endcase
  end

  always_comb begin
    case (nxt)
      S_UP1:  load = CNT_W'(t1_cfg) * CNT_W'(T1_STEP);
      S_UP2:  load = CNT_W'(t2_cfg) * CNT_W'(T25_STEP);
      S_DN3:  load = CNT_W'(t3_cfg) * CNT_W'(T34_STEP);
      S_DN4:  load = CNT_W'(t4_cfg) * CNT_W'(T34_STEP);
      S_LOCK: load = CNT_W'(t5_cfg) * CNT_W'(T25_STEP);
      default: load = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_OFF;
      cnt <= '0;
    end else begin
      st <= nxt;
      if (nxt != st) cnt <= load;
      else if (!done && tick_ms) cnt <= cnt - 1'b1;
    end
  end

  assign panel_vdd_en = (st == S_UP1) | (st == S_UP2) | (st == S_ON) |
                        (st == S_DN3) | (st == S_DN4);
  assign link_valid   = (st == S_UP2) | (st == S_ON) | (st == S_DN3);
  assign bkl_en       = (st == S_ON) & bkl_allow;
  assign link_oe      = link_valid | gnd_idle;
  assign link_zero    = gnd_idle & ~link_valid;
endmodule

module lcd_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic link_en,
  input logic pll_locked,
  input logic hsync_ok,
  input logic vsync_ok,
  input logic pclk_ok,
  input logic bkl_allow,
  input logic panel_vdd_en,
  input logic link_valid,
  input logic bkl_en,
  input logic link_zero
);
  // R4
  bkl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bkl_en |-> (bkl_allow && link_valid && panel_vdd_en));
  // R3
  valid_needs_vdd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> panel_vdd_en);
  // R2
  vdd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panel_vdd_en) |-> $past(link_en && pll_locked && hsync_ok && vsync_ok && pclk_ok));
  // R5
  data_before_vdd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_valid) |-> panel_vdd_en);
  // R8
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_zero |-> !link_valid);
endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .link_en(link_en), .pll_locked(pll_locked),
  .hsync_ok(hsync_ok), .vsync_ok(vsync_ok), .pclk_ok(pclk_ok),
  .bkl_allow(bkl_allow), .panel_vdd_en(panel_vdd_en),
  .link_valid(link_valid), .bkl_en(bkl_en), .link_zero(link_zero)
);

// File: tb/lcd_pwr_seq_tb.sv
module lcd_pwr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV = 4;

  logic clk = 0, rst_n = 0, tick_ms = 0;
  logic link_en = 0, pll_locked = 0, hsync_ok = 0, vsync_ok = 0, pclk_ok = 0;
  logic bkl_allow = 1, gnd_idle = 1;
  logic [5:0] t1_cfg = 0;
  logic [9:0] t2_cfg = 0, t5_cfg = 0;
  logic [7:0] t3_cfg = 0, t4_cfg = 0;
  logic panel_vdd_en, link_valid, bkl_en, link_oe, link_zero;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_pwr_seq dut_i (.*);

  // behavioural reference: phase 0 idle,1 wait1,2 wait2,3 up,4 wait3,5 wait4,6 lockout
  int ph, rem, np;
  bit g;
  function automatic int delay_of(int p);
    case (p)
      1: return int'(t1_cfg) * 50;
      2: return int'(t2_cfg);
      4: return int'(t3_cfg) * 2;
      5: return int'(t4_cfg) * 2;
      6: return int'(t5_cfg);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; rem = 0;
    end else begin
      g = link_en && pll_locked && hsync_ok && vsync_ok && pclk_ok;
      np = ph;
      if (ph == 0 && g) np = 1;
      else if (ph == 1) np = !g ? 5 : (rem == 0 ? 2 : 1);
      else if (ph == 2) np = !g ? 4 : (rem == 0 ? 3 : 2);
      else if (ph == 3) np = !g ? 4 : 3;
      else if (ph >= 4 && rem == 0) np = (ph == 6) ? 0 : ph + 1;
      if (np != ph) rem = delay_of(np);
      else if (rem > 0 && tick_ms) rem = rem - 1;
      ph = np;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit mv, ml, mb;
    mv = (ph >= 1 && ph <= 5);
    ml = (ph >= 2 && ph <= 4);
    mb = (ph == 3) && bkl_allow;
    chk(panel_vdd_en == mv, "R2/R5 vdd", panel_vdd_en, mv);
    chk(link_valid == ml, "R3/R5 valid", link_valid, ml);
    chk(bkl_en == mb, "R4 bkl", bkl_en, mb);
    chk(link_oe == (ml | gnd_idle), "R8 oe", link_oe, ml | gnd_idle);
    chk(link_zero == (!ml && gnd_idle), "R8 zero", link_zero, !ml && gnd_idle);
  end

  initial forever begin
    repeat (TICK_DIV - 1) @(negedge clk);
    tick_ms = 1;
    @(negedge clk);
    tick_ms = 0;
  end

  task automatic set_go(input bit v);
    link_en = v; pll_locked = v; hsync_ok = v; vsync_ok = v; pclk_ok = v;
  endtask

  task automatic wait_sig(input int which, input bit val, input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if ((which == 0 ? panel_vdd_en : which == 1 ? link_valid : bkl_en) == val) return;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!panel_vdd_en && !link_valid && !bkl_en, "R1 reset", panel_vdd_en, 0);
    chk(link_zero && link_oe, "R1 pads", link_zero, 1);
    rst_n = 1;
    @(negedge clk);
    chk(!panel_vdd_en, "R1 idle", panel_vdd_en, 0);

    t1_cfg = 1; t2_cfg = 3; t3_cfg = 2; t4_cfg = 1; t5_cfg = 5;
    set_go(1);
    @(negedge clk);
    chk(panel_vdd_en, "R2 start", panel_vdd_en, 1);
    wait_sig(2, 1, 2000);
    chk(bkl_en, "R3 up", bkl_en, 1);

    hsync_ok = 0;
    @(negedge clk);
    chk(!bkl_en, "R5 bkl drop", bkl_en, 0);
    repeat (3) @(negedge clk);
    hsync_ok = 1;
    repeat (2) @(negedge clk);
    // R6
    chk(!bkl_en && link_valid, "R6 continue", bkl_en, 0);
    wait_sig(0, 0, 2000);
    chk(!panel_vdd_en, "R6 complete", panel_vdd_en, 0);
    repeat (10) @(negedge clk);
    // R7
    chk(!panel_vdd_en, "R7 lockout", panel_vdd_en, 0);
    wait_sig(0, 1, 200);
    chk(panel_vdd_en, "R7 restart", panel_vdd_en, 1);

    bkl_allow = 0;
    wait_sig(1, 1, 2000);
    repeat (40) @(negedge clk);
    chk(!bkl_en && link_valid, "R4 no bkl", bkl_en, 0);
    link_en = 0;
    wait_sig(0, 0, 2000);
    chk(!panel_vdd_en, "R5 sw off", panel_vdd_en, 0);
    bkl_allow = 1;
    repeat (40) @(negedge clk);

    t1_cfg = 0; t2_cfg = 0; t3_cfg = 0; t4_cfg = 0; t5_cfg = 0;
    link_en = 1;
    @(negedge clk); chk(panel_vdd_en && !link_valid, "R9 step1", link_valid, 0);
    @(negedge clk); chk(link_valid && !bkl_en, "R9 step2", bkl_en, 0);
    @(negedge clk); chk(bkl_en, "R9 step3", bkl_en, 1);
    set_go(0);
    repeat (6) @(negedge clk);

    t1_cfg = 2; t4_cfg = 1;
    set_go(1);
    repeat (20) @(negedge clk);
    pll_locked = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      // R10
      chk(!link_valid, "R10 no valid", link_valid, 0);
    end
    chk(!panel_vdd_en, "R10 vdd off", panel_vdd_en, 0);

    gnd_idle = 0;
    @(negedge clk);
    chk(!link_oe && !link_zero, "R8 float", link_oe, 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule